// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block adds two N-bit operands and a carry-in. It returns an N-bit sum and a carry-out. It has no clock and no state. Every bit column first makes a generate term (both operand bits set) and a propagate term (either operand bit set). Inside each K-bit group these terms are folded into a single group generate and a single group propagate. A chain of AND-OR stages, one stage per group, then moves the carry from group to group, so a carry no longer steps through every bit. Inside a group, the local carries ripple from the group's incoming carry, and each sum bit is the XOR of the two operand bits and the carry below it.

The block is meant for a datapath that needs a wide adder whose carry path is shorter than a plain ripple chain. The group width K sets the balance between the length of the chain across groups and the ripple length inside one group.

Top module: `cla_adder`

## Requirements
- R1: For every pair of operands and both carry-in values, the concatenation {cout_o, sum_o} equals a_i + b_i + cin_i, computed at N+1 bits.
- R2: The carry entering group g (bits g*K and up) equals bit g*K of the (g*K+1)-bit sum of the operands' lower g*K bits plus cin_i. The carry into group 0 is cin_i.
- R3: cout_o equals the carry leaving the most significant group.
- R4: When a_i = ~b_i (every column propagates and none generates), cout_o equals cin_i. sum_o is all ones when cin_i = 0 and all zeros when cin_i = 1.
- R5: When a_i and b_i are both zero (every column kills), cout_o is 0 and sum_o is cin_i zero-extended.
- R6: When a_i and b_i are both all ones (every column generates), cout_o is 1. sum_o is all ones except bit 0, which equals cin_i.
- R7: Any N that is a multiple of K gives a working adder. A non-multiple is rejected at elaboration. A second configuration (N=6, K=3) is also checked exhaustively.
- R8: The block is purely combinational. A new operand set is reflected at the outputs within the same cycle, with no clock or reset involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Sum bits |
| cout_o | output | 1 | Carry out of the most significant group |

## Verification
Two functions meet in one evaluation: a carry skipping across every group through the AND-OR chain, and ripple sum formation inside the last group, which depends on that carry.

The bench provokes this with all-propagate operands (a_i = ~b_i) while cin_i toggles, so a single carry must cross every group and then ripple through the top group within the same cycle. It also applies operands that generate a carry at the top bit of one group and propagate it through the next. The results are judged against the arithmetic sum, and the carry at every group boundary is compared with the carry derived from the lower bits.

// File: rtl/cla_pkg.sv
`timescale 1ns/1ps
package cla_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Combine an upper span with the adjacent lower span.
  function automatic gp_t gp_merge(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/cla_bit_pg.sv
`timescale 1ns/1ps
module cla_bit_pg
  import cla_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output gp_t  [W-1:0] gp_o
);

  for (genvar i = 0; i < W; i++) begin : g_col
    assign gp_o[i].g = a_i[i] & b_i[i];
    assign gp_o[i].p = a_i[i] | b_i[i];
  end

endmodule

// File: rtl/cla_group_pg.sv
`timescale 1ns/1ps
module cla_group_pg
  import cla_pkg::*;
#(
  parameter int unsigned K = 4
) (
  input  gp_t [K-1:0] bit_gp_i,
  output gp_t         grp_gp_o
);

  gp_t [K-1:0] span;  // span[i] covers bits i..0

  assign span[0] = bit_gp_i[0];
  for (genvar i = 1; i < K; i++) begin : g_merge
    assign span[i] = gp_merge(bit_gp_i[i], span[i-1]);
  end

  assign grp_gp_o = span[K-1];

endmodule

// File: rtl/cla_carry_chain.sv
`timescale 1ns/1ps
module cla_carry_chain
  import cla_pkg::*;
#(
  parameter int unsigned NG = 8
) (
  input  gp_t [NG-1:0] grp_gp_i,
  input  logic         cin_i,
  output logic [NG:0]  carry_o
);

  assign carry_o[0] = cin_i;
  for (genvar g = 0; g < NG; g++) begin : g_hop
    assign carry_o[g+1] = grp_gp_i[g].g | (grp_gp_i[g].p & carry_o[g]);
  end

endmodule

// File: rtl/cla_group_sum.sv
`timescale 1ns/1ps
module cla_group_sum
  import cla_pkg::*;
#(
  parameter int unsigned K = 4
) (
  input  logic [K-1:0] a_i,
  input  logic [K-1:0] b_i,
  input  gp_t  [K-1:0] bit_gp_i,
  input  logic         cin_i,
  output logic [K-1:0] sum_o
);

  logic [K-1:0] c_in;  // carry into each bit of the group

  assign c_in[0] = cin_i;
  for (genvar i = 1; i < K; i++) begin : g_ripple
    assign c_in[i] = bit_gp_i[i-1].g | (bit_gp_i[i-1].p & c_in[i-1]);
  end

  for (genvar i = 0; i < K; i++) begin : g_sum
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c_in[i];
  end

endmodule

// File: rtl/cla_adder.sv
`timescale 1ns/1ps
module cla_adder
  import cla_pkg::*;
#(
  parameter int unsigned N = 32,
  parameter int unsigned K = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);

  localparam int unsigned NG = N / K;

  if ((N % K) != 0 || K == 0) begin : g_bad_cfg
    $error("cla_adder: N must be a nonzero multiple of K");
  end

  gp_t  [N-1:0]  bit_gp;
  gp_t  [NG-1:0] grp_gp;
  logic [NG:0]   grp_carry;

  cla_bit_pg #(.W(N)) u_pg (
    .a_i  (a_i),
    .b_i  (b_i),
    .gp_o (bit_gp)
  );

  for (genvar g = 0; g < NG; g++) begin : g_grp
    cla_group_pg #(.K(K)) u_gpg (
      .bit_gp_i (bit_gp[g*K +: K]),
      .grp_gp_o (grp_gp[g])
    );

    cla_group_sum #(.K(K)) u_sum (
      .a_i      (a_i[g*K +: K]),
      .b_i      (b_i[g*K +: K]),
      .bit_gp_i (bit_gp[g*K +: K]),
      .cin_i    (grp_carry[g]),
      .sum_o    (sum_o[g*K +: K])
    );
  end

  cla_carry_chain #(.NG(NG)) u_chain (
    .grp_gp_i (grp_gp),
    .cin_i    (cin_i),
    .carry_o  (grp_carry)
  );

  assign cout_o = grp_carry[NG];

endmodule

// File: rtl/cla_adder_chk.sv
`timescale 1ns/1ps
module cla_adder_chk #(
  parameter int unsigned N = 32,
  parameter int unsigned K = 4
) (
  input logic [N-1:0]   a_i,
  input logic [N-1:0]   b_i,
  input logic           cin_i,
  input logic [N-1:0]   sum_i,
  input logic           cout_i,
  input logic [N/K:0]   grp_c_i
);

  localparam int unsigned NG = N / K;

  function automatic logic carry_at(logic [N-1:0] a, logic [N-1:0] b,
                                    logic ci, int pos);
    logic [N:0] m;
    logic [N:0] s;
    m = ({{N{1'b0}}, 1'b1} << pos) - 1'b1;
    s = ({1'b0, a} & m) + ({1'b0, b} & m) + {{N{1'b0}}, ci};
    return s[pos];
  endfunction

  always_comb begin
    // R1
    p_arith_r1: assert ({cout_i, sum_i} == ({1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i}))
      else $error("R1 arithmetic mismatch");
    // R3
    p_cout_top_r3: assert (cout_i == grp_c_i[NG])
      else $error("R3 cout differs from top group carry");
    // R4
    if ((a_i ^ b_i) == {N{1'b1}}) begin
      p_pass_r4: assert (cout_i == cin_i && sum_i == {N{~cin_i}})
        else $error("R4 propagate pass-through wrong");
    end
    // R5
    if ((a_i | b_i) == '0) begin
      p_kill_r5: assert (!cout_i && sum_i == {{(N-1){1'b0}}, cin_i})
        else $error("R5 kill case wrong");
    end
  end

  for (genvar g = 0; g <= NG; g++) begin : g_gc
    always_comb begin
      // R2
      p_grp_carry_r2: assert (grp_c_i[g] == carry_at(a_i, b_i, cin_i, g*K))
        else $error("R2 group carry mismatch");
    end
  end

endmodule

bind cla_adder cla_adder_chk #(.N(N), .K(K)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .cin_i   (cin_i),
  .sum_i   (sum_o),
  .cout_i  (cout_o),
  .grp_c_i (grp_carry)
);

// File: tb/cla_adder_bench.sv
`timescale 1ns/1ps
module cla_adder_bench;

  localparam int unsigned NB = 32;
  localparam int unsigned KB = 4;
  localparam int unsigned NS = 6;
  localparam int unsigned KS = 3;

  typedef struct {
    logic [NB:0] exp_big;
    logic [NS:0] exp_small;
    string       req;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [NB-1:0] a_big = '0, b_big = '0;
  logic          c_big = 1'b0;
  logic [NB-1:0] s_big;
  logic          co_big;

  logic [NS-1:0] a_sm = '0, b_sm = '0;
  logic          c_sm = 1'b0;
  logic [NS-1:0] s_sm;
  logic          co_sm;

  cla_adder #(.N(NB), .K(KB)) u_cla_adder (
    .a_i (a_big), .b_i (b_big), .cin_i (c_big), .sum_o (s_big), .cout_o (co_big)
  );

  cla_adder #(.N(NS), .K(KS)) u_cla_adder_small (
    .a_i (a_sm), .b_i (b_sm), .cin_i (c_sm), .sum_o (s_sm), .cout_o (co_sm)
  );

  item_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic drive(input logic [NB-1:0] a, input logic [NB-1:0] b, input logic ci,
                       input logic [NS-1:0] as, input logic [NS-1:0] bs, input logic cs,
                       input string req);
    item_t it;
    @(posedge clk);
    a_big = a; b_big = b; c_big = ci;
    a_sm = as; b_sm = bs; c_sm = cs;
    it.exp_big   = {1'b0, a} + {1'b0, b} + {{NB{1'b0}}, ci};
    it.exp_small = {1'b0, as} + {1'b0, bs} + {{NS{1'b0}}, cs};
    it.req       = req;
    sb_q.push_back(it);
  endtask

  // Monitor: compares away from the driving edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_cmp++;
      if ({co_big, s_big} !== it.exp_big) begin
        n_bad++;
        $display("FAIL %s big: got %h exp %h", it.req, {co_big, s_big}, it.exp_big);
      end
      n_cmp++;
      if ({co_sm, s_sm} !== it.exp_small) begin
        n_bad++;
        $display("FAIL %s small: got %h exp %h", it.req, {co_sm, s_sm}, it.exp_small);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung exp finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] ones;
    ones = '1;
    repeat (3) @(posedge clk);
    // Reset state: inputs idle at zero, outputs zero (R5, R8)
    @(negedge clk);
    n_cmp++;
    if ({co_big, s_big} !== '0) begin
      n_bad++;
      $display("FAIL R5 reset idle: got %h exp 0", {co_big, s_big});
    end
    rst_ni = 1'b1;

    // R5 all-kill
    drive('0, '0, 1'b0, '0, '0, 1'b0, "R5");
    drive('0, '0, 1'b1, '0, '0, 1'b1, "R5");
    // R4 all-propagate, carry crosses every group then ripples in the top group
    drive(32'hA5A5_0F0F, ~32'hA5A5_0F0F, 1'b0, 6'h2A, 6'h15, 1'b0, "R4");
    drive(32'hA5A5_0F0F, ~32'hA5A5_0F0F, 1'b1, 6'h2A, 6'h15, 1'b1, "R4");
    drive('0, ones, 1'b1, '0, '1, 1'b1, "R4");
    // R6 all-generate
    drive(ones, ones, 1'b0, '1, '1, 1'b0, "R6");
    drive(ones, ones, 1'b1, '1, '1, 1'b1, "R6");
    // R2 generate at top bit of a group, propagate through the next
    for (int g = 0; g < int'(NB / KB) - 1; g++) begin
      logic [NB-1:0] av, bv;
      av = ('1 << (g*KB + KB - 1)) & ~(('1 << ((g+2)*KB)));
      bv = 32'h1 << (g*KB + KB - 1);
      drive(av, bv, 1'b0, 6'h04, 6'h04, 1'b0, "R2");
    end
    // R3 carry-out from the top group only
    drive(32'h8000_0000, 32'h8000_0000, 1'b0, 6'h20, 6'h20, 1'b0, "R3");
    drive(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 6'h1F, 6'h01, 1'b0, "R3");
    // R7 exhaustive small configuration, R1 random large vectors
    for (int i = 0; i < (1 << (2*NS + 1)); i++) begin
      logic [NS-1:0] as, bs;
      logic cs;
      as = i[NS-1:0];
      bs = i[2*NS-1:NS];
      cs = i[2*NS];
      drive($urandom(), $urandom(), i[0], as, bs, cs, "R7/R1");
    end
    for (int i = 0; i < 2000; i++) begin
      drive($urandom(), $urandom(), 1'($urandom()), 6'($urandom()), 6'($urandom()),
            1'($urandom()), "R1");
    end
    // R8: outputs follow inputs between edges with no clock involvement
    @(posedge clk);
    #1;
    a_big = 32'h0000_FFFF; b_big = 32'h0000_0001; c_big = 1'b0;
    #0.5;
    n_cmp++;
    if ({co_big, s_big} !== 33'h0_0001_0000) begin
      n_bad++;
      $display("FAIL R8 comb: got %h exp %h", {co_big, s_big}, 33'h0_0001_0000);
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule